// File: doc/BRIEF.md
# Lockable Boot-Loaded Configuration Register

This block is a 32-bit device configuration register. Its fields select pad routing, debug access, trace, a watchdog postscale ratio and similar settings. While boot is still in progress, the block takes its contents from a configuration word read out of nonvolatile memory. It accepts that word only when the read reports neither a fail nor a blank/erased condition. The debug-select field and the wake-up bit are never taken from the boot word.

Once `boot_done` is high, software reaches the register through a simple write strobe and a continuous read bus. A 2-bit lock level decides which bits a write may change:

- Level `2'b00` opens every implemented bit.
- Level `2'b10` opens only the reset-handling bit 14.
- Levels `2'b01` and `2'b11` freeze the register.

Bit 7 is not stored. A write of 1 to bit 7 launches a request that crosses into a separate low-power clock domain and emerges there as a pulse exactly one low-power cycle wide.

Top module: `cfg_lock_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x1F00443B.
- R2: A `boot_vld` strobe while `boot_done` is low, with `boot_fail` and `boot_blank` both low, copies `boot_word` into every implemented bit except bits [1:0] and bit 7. Bits [1:0] keep their current value.
- R3: A `boot_vld` strobe that comes with `boot_fail` or `boot_blank` high leaves the register unchanged.
- R4: Software writes while `boot_done` is low are ignored. `boot_vld` strobes while `boot_done` is high are ignored.
- R5: With `boot_done` high and `lock_lvl` = 2'b00, a write sets every implemented bit from `wr_data`, subject to R8.
- R6: With `lock_lvl` = 2'b10, a write changes only bit 14.
- R7: With `lock_lvl` = 2'b01 or 2'b11, a write changes no bit.
- R8: The postscale field in bits [28:24] holds a code whose ratio is 2^code. A software write of a code above 20 stores 20.
- R9: Bits 31, 7, 6 and 2 always read as 0.
- R10: With `boot_done` high and any lock level, writing 1 to bit 7 produces exactly one `wake_pulse` that is one `lp_clk` cycle wide. Bit 7 of a boot word never produces a pulse.
- R11: A bit 7 request made while an earlier request has not yet finished its pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_clk | input | 1 | Low-power domain clock |
| boot_vld | input | 1 | One-cycle strobe: configuration word valid |
| boot_word | input | 32 | Configuration word from nonvolatile memory |
| boot_fail | input | 1 | Read of the word failed |
| boot_blank | input | 1 | Word location is blank/erased |
| boot_done | input | 1 | Boot window is over; software access open |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| lock_lvl | input | 2 | Lock level governing write permission |
| rd_data | output | 32 | Current register contents |
| wake_pulse | output | 1 | Wake-up pulse in the `lp_clk` domain |

## Verification
The following rules are checked by assertions on every clock:
- Unimplemented bits stay at 0.
- Writes before boot and writes under a closed lock leave the register stable.
- Lock level 2'b10 leaves every bit other than 14 untouched.
- Rejected or late boot loads change nothing.
- The debug bits survive any boot load.
- The postscale code after an open write never exceeds 20.
- Every wake pulse ends after a single `lp_clk` cycle.

Some behaviour needs the bench's scenarios:
- That a trusted word actually lands, with specific values.
- That the reset value is right.
- That one request yields exactly one pulse across the clock crossing.
- That a request arriving while the crossing is busy yields no pulse.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int          CFG_W     = 32;
  localparam logic [31:0] CFG_RESET = 32'h1F00443B;
  // bits that hold state: all except 31, 7, 6, 2
  localparam logic [31:0] CFG_IMPL  = 32'h7FFFFF3B;
  // bits the boot word never touches: debug select [1:0] and wake bit 7
  localparam logic [31:0] BOOT_SKIP = 32'h00000083;
  localparam logic [31:0] BOOT_MASK = CFG_IMPL & ~BOOT_SKIP;
  localparam int          WAKE_BIT  = 7;
  localparam int          SOFT_BIT  = 14;
  localparam int          PS_LSB    = 24;
  localparam int          PS_W      = 5;
  localparam logic [PS_W-1:0] PS_MAX = 5'd20;

  typedef enum logic [1:0] {
    LOCK_OPEN = 2'b00,
    LOCK_L1   = 2'b01,
    LOCK_SOFT = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_e;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_wr_policy.sv
module cfg_wr_policy
  import cfg_lock_pkg::*;
(
  input  logic             wr_en,
  input  logic             boot_done,
  input  logic [1:0]       lock_lvl,
  output logic [CFG_W-1:0] wmask
);
  logic [CFG_W-1:0] lock_mask;

  always_comb begin
    unique case (lock_e'(lock_lvl))
      LOCK_OPEN: lock_mask = CFG_IMPL;
      LOCK_SOFT: lock_mask = CFG_W'(1) << SOFT_BIT;
      default:   lock_mask = '0;
    endcase
  end

  always_comb begin
    wmask = '0;
    if (wr_en && boot_done) wmask = lock_mask & ~(CFG_W'(1) << WAKE_BIT);
  end
endmodule

// File: rtl/cfg_wake_xfer.sv
module cfg_wake_xfer #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic srst_n,
  input  logic lp_clk,
  input  logic lp_srst_n,
  input  logic req,
  output logic pulse
);
  logic            tgl_q, tgl_d;
  logic [SYNC-1:0] ack_sync_q;
  logic            busy;

  logic [SYNC-1:0] req_sync_q;
  logic            seen_q, done_q, pulse_q;
  logic            pulse_d;

  // source side: toggle on an accepted request
  assign busy  = tgl_q ^ ack_sync_q[SYNC-1];
  assign tgl_d = (req && !busy) ? ~tgl_q : tgl_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tgl_q      <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      tgl_q      <= tgl_d;
      ack_sync_q <= {ack_sync_q[SYNC-2:0], done_q};
    end
  end

  // low-power side: detect a toggle edge, emit one cycle, then acknowledge
  assign pulse_d = req_sync_q[SYNC-1] ^ seen_q;

  always_ff @(posedge lp_clk or negedge lp_srst_n) begin
    if (!lp_srst_n) begin
      req_sync_q <= '0;
      seen_q     <= 1'b0;
      done_q     <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[SYNC-2:0], tgl_q};
      seen_q     <= req_sync_q[SYNC-1];
      done_q     <= seen_q;
      pulse_q    <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg
  import cfg_lock_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lp_clk,
  input  logic        boot_vld,
  input  logic [31:0] boot_word,
  input  logic        boot_fail,
  input  logic        boot_blank,
  input  logic        boot_done,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [1:0]  lock_lvl,
  output logic [31:0] rd_data,
  output logic        wake_pulse
);
  logic             srst_n, lp_srst_n;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [CFG_W-1:0] wmask;
  logic [CFG_W-1:0] wr_val;
  logic             boot_take;
  logic             wake_req;
  logic [PS_W-1:0]  ps_in;

  cfg_rst_sync #(.STAGES(SYNC)) u_rst_main (.clk(clk),    .arst_n(rst_n), .srst_n(srst_n));
  cfg_rst_sync #(.STAGES(SYNC)) u_rst_lp   (.clk(lp_clk), .arst_n(rst_n), .srst_n(lp_srst_n));

  cfg_wr_policy u_policy (
    .wr_en    (wr_en),
    .boot_done(boot_done),
    .lock_lvl (lock_lvl),
    .wmask    (wmask)
  );

  assign boot_take = boot_vld && !boot_done && !boot_fail && !boot_blank;

  // postscale clamp on software data
  assign ps_in = wr_data[PS_LSB +: PS_W];
  always_comb begin
    wr_val = wr_data;
    if (ps_in > PS_MAX) wr_val[PS_LSB +: PS_W] = PS_MAX;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (boot_take) cfg_d = (boot_word & BOOT_MASK) | (cfg_q & ~BOOT_MASK);
    if (|wmask)    cfg_d = (wr_val & wmask) | (cfg_q & ~wmask);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cfg_q <= CFG_RESET;
    else         cfg_q <= cfg_d;
  end

  assign rd_data  = cfg_q & CFG_IMPL;
  assign wake_req = wr_en && boot_done && wr_data[WAKE_BIT];

  cfg_wake_xfer #(.SYNC(SYNC)) u_wake (
    .clk      (clk),
    .srst_n   (srst_n),
    .lp_clk   (lp_clk),
    .lp_srst_n(lp_srst_n),
    .req      (wake_req),
    .pulse    (wake_pulse)
  );
endmodule

// File: rtl/cfg_lock_reg_chk.sv
module cfg_lock_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lp_clk,
  input logic        boot_vld,
  input logic        boot_fail,
  input logic        boot_blank,
  input logic        boot_done,
  input logic        wr_en,
  input logic [1:0]  lock_lvl,
  input logic [31:0] rd_data,
  input logic        wake_pulse
);
  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] == 1'b0) && (rd_data[7:6] == 2'b00) && (rd_data[2] == 1'b0));

  p_preboot_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !boot_done && !boot_vld) |=> $stable(rd_data));

  p_late_boot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_vld && boot_done && !wr_en) |=> $stable(rd_data));

  p_bad_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_vld && !boot_done && (boot_fail || boot_blank)) |=> $stable(rd_data));

  p_debug_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_vld && !boot_done) |=> $stable(rd_data[1:0]));

  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && boot_done && lock_lvl[0]) |=> $stable(rd_data));

  p_soft_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && boot_done && lock_lvl == 2'b10) |=> ($stable(rd_data[13:0]) && $stable(rd_data[31:15])));

  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && boot_done && lock_lvl == 2'b00) |=> (rd_data[28:24] <= 5'd20));

  p_one_cycle_r10: assert property (@(posedge lp_clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
endmodule

bind cfg_lock_reg cfg_lock_reg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lp_clk    (lp_clk),
  .boot_vld  (boot_vld),
  .boot_fail (boot_fail),
  .boot_blank(boot_blank),
  .boot_done (boot_done),
  .wr_en     (wr_en),
  .lock_lvl  (lock_lvl),
  .rd_data   (rd_data),
  .wake_pulse(wake_pulse)
);

// File: tb/tb_cfg_lock_reg.sv
`timescale 1ns/1ps
module tb_cfg_lock_reg;
  logic        clk = 1'b0;
  logic        lp_clk = 1'b0;
  logic        rst_n;
  logic        boot_vld, boot_fail, boot_blank, boot_done, wr_en;
  logic [31:0] boot_word, wr_data, rd_data;
  logic [1:0]  lock_lvl;
  logic        wake_pulse;
  int          checks = 0;
  int          errors = 0;
  int          pulses = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;
  always #18.5 lp_clk = ~lp_clk;

  cfg_lock_reg dut (
    .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk),
    .boot_vld(boot_vld), .boot_word(boot_word), .boot_fail(boot_fail),
    .boot_blank(boot_blank), .boot_done(boot_done),
    .wr_en(wr_en), .wr_data(wr_data), .lock_lvl(lock_lvl),
    .rd_data(rd_data), .wake_pulse(wake_pulse)
  );

  always @(negedge lp_clk) if (wake_pulse) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic boot_load(input logic [31:0] w, input logic f, input logic b);
    @(negedge clk);
    boot_vld = 1'b1; boot_word = w; boot_fail = f; boot_blank = b;
    @(negedge clk);
    boot_vld = 1'b0; boot_fail = 1'b0; boot_blank = 1'b0;
  endtask

  task automatic sw_write(input logic [31:0] d, input logic [1:0] lk);
    @(negedge clk);
    lock_lvl = lk; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lp_wait();
    repeat (12) @(posedge lp_clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset value", rd_data, 32'h1F00443B);
  endtask

  task automatic t_preboot();
    sw_write(32'h0000_0000, 2'b00);
    check("R4 write before boot_done", rd_data, 32'h1F00443B);
    lp_wait();
    check("R4 no pulse before boot_done", pulses, 0);
  endtask

  task automatic t_bad_boot();
    boot_load(32'h0000_0000, 1'b1, 1'b0);
    check("R3 fail blocks load", rd_data, 32'h1F00443B);
    boot_load(32'h0000_0000, 1'b0, 1'b1);
    check("R3 blank blocks load", rd_data, 32'h1F00443B);
  endtask

  task automatic t_good_boot();
    boot_load(32'h0000_0000, 1'b0, 1'b0);
    check("R2 zero word, debug bits kept", rd_data, 32'h0000_0003);
    boot_load(32'hFFFF_FFFF, 1'b0, 1'b0);
    check("R2 all-ones word", rd_data, 32'h7FFF_FF3B);
    boot_load(32'h1234_5678, 1'b0, 1'b0);
    check("R2 mixed word", rd_data, 32'h1234_563B);
    lp_wait();
    check("R10 boot bit 7 gives no pulse", pulses, 0);
  endtask

  task automatic t_late_boot();
    boot_load(32'h0000_0000, 1'b0, 1'b0);
    check("R4 boot strobe after done ignored", rd_data, 32'h1234_563B);
  endtask

  task automatic t_open_lock();
    sw_write(32'h0000_0000, 2'b00);
    check("R5 open write zero", rd_data, 32'h0000_0000);
    sw_write(32'h0500_0011, 2'b00);
    check("R5 open write pattern", rd_data, 32'h0500_0011);
    sw_write(32'hFFFF_FF7F, 2'b00);
    check("R8 clamp to 20 and R9 unimplemented zero", rd_data, 32'h74FF_FF3B);
    sw_write(32'h0000_0000, 2'b00);
  endtask

  task automatic t_soft_lock();
    sw_write(32'hFFFF_FF7F, 2'b10);
    check("R6 level 10 sets only bit 14", rd_data, 32'h0000_4000);
    sw_write(32'h0000_0000, 2'b00);
    sw_write(32'h0A0F_0F03, 2'b00);
    sw_write(32'h0000_0000, 2'b10);
    check("R6 level 10 other bits held", rd_data, 32'h0A0F_0F03);
  endtask

  task automatic t_closed_lock();
    sw_write(32'hFFFF_FF7F, 2'b11);
    check("R7 level 11 blocks", rd_data, 32'h0A0F_0F03);
    sw_write(32'h0000_0000, 2'b01);
    check("R7 level 01 blocks", rd_data, 32'h0A0F_0F03);
  endtask

  task automatic t_wake();
    int base;
    base = pulses;
    sw_write(32'h0000_0080, 2'b11);
    check("R9 bit 7 reads zero", {31'd0, rd_data[7]}, 32'd0);
    lp_wait();
    check("R10 one pulse per request", pulses, base + 1);
    sw_write(32'h0000_0080, 2'b00);
    sw_write(32'h0000_0080, 2'b00);
    lp_wait();
    check("R11 busy request dropped", pulses, base + 2);
    sw_write(32'h0000_0080, 2'b10);
    lp_wait();
    check("R10 pulse after idle", pulses, base + 3);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; boot_vld = 1'b0; boot_word = '0; boot_fail = 1'b0;
    boot_blank = 1'b0; boot_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    lock_lvl = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge lp_clk);
    @(negedge clk);
    t_reset();
    t_preboot();
    t_bad_boot();
    t_good_boot();
    @(negedge clk); boot_done = 1'b1;
    t_late_boot();
    t_open_lock();
    t_soft_lock();
    t_closed_lock();
    t_wake();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule